// File: doc/BRIEF.md
# Sidetone Filter Control Register Block

This block is the memory-mapped control face of an audio sidetone filter. Software reaches it over a simple register bus that carries a write strobe, a read strobe, a byte address and 32-bit data in each direction. Through it, software sets two signed channel gains, a clock auto-idle control and the path enable. It also fills a table of signed 16-bit filter taps that the filter datapath reads in parallel.

Taps enter through a single write-only port. The port auto-increments its target entry, but only while a load-enable bit is set. Each rising edge of that bit restarts the fill at entry 0. Once the last entry has been written, a read-only completion flag rises. The filter path is enabled towards the datapath only when a complete table is present, so a partly written table is never used. Read data is registered, so it appears one cycle after the read strobe.

Top module: `stn_cfg_regs`

## Requirements
- R1: After reset, the gains are 0, the control register reads 0, the configuration register reads 1, `gate_req` is 1, `path_on` is 0 and `rdata` is 0.
- R2: Offset 0x00 reads the constant 0x0000_0010. Writes to it change nothing.
- R3: Bit 0 of the configuration register at offset 0x10 drives `gate_req` and reads back. A value of 1 allows clock gating, and a value of 0 keeps the clock running.
- R4: The gain register at offset 0x24 places channel 0 in bits 15:0, which drive `gain_a`, and channel 1 in bits 31:16, which drive `gain_b`. It reads back as written.
- R5: The control register sits at offset 0x2C. Bit 0 is the path enable, bit 1 is the load enable and bit 2 is the completion flag. The completion flag is read-only, so writing a 1 to bit 2 has no effect.
- R6: While the load enable is 1, each write to offset 0x28 stores wdata[15:0] into the next table entry, starting at entry 0. Entry i appears on `taps[i*16 +: 16]`.
- R7: Writes to offset 0x28 while the load enable is 0 leave the table unchanged. Reads of offset 0x28 return 0.
- R8: The completion flag reads 0 in the cycle right after the 128th tap write. It reads 1 one cycle later. Further tap writes are ignored until a restart.
- R9: Setting the load enable from 0 to 1 restarts the fill at entry 0 and clears the completion flag. Writing 0 to the load enable also clears the flag.
- R10: `path_on` is 1 only when the path enable is 1 and the table was completely filled after the latest restart. It stays 1 after the load enable is cleared.
- R11: Unused offsets, including 0x18 and 0x1C, read 0 and ignore writes.
- R12: `rdata` updates on the clock edge that samples `rd_en`, and holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| taps | output | 2048 | Tap table, entry i at bits i*16 +: 16 |
| gain_a | output | 16 | Channel 0 gain |
| gain_b | output | 16 | Channel 1 gain |
| path_on | output | 1 | Sidetone path enable to the datapath |
| gate_req | output | 1 | Clock-gating permission |

## Verification
The assertions assume that `wr_en` and `rd_en` are never known-invalid after reset, and that a write and a read never target conflicting state in a way that depends on their ordering. They also assume that the load-enable bit changes only through writes to the control register. The stimulus drives at most one bus operation per cycle. It changes inputs only on the falling clock edge and leaves both strobes low outside the operations. It touches the tap port only in three ways: after a deliberate clear of the load enable, during a full fill, or during a short restarted fill.

// File: rtl/stn_cfg_regs.sv
module stn_cfg_regs #(
  parameter int          ADDR_W    = 8,
  parameter int          TAP_N     = 128,
  parameter int          TAP_W     = 16,
  parameter logic [31:0] REV_VALUE = 32'h0000_0010
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic [TAP_N*TAP_W-1:0] taps,
  output logic [15:0]            gain_a,
  output logic [15:0]            gain_b,
  output logic                   path_on,
  output logic                   gate_req
);

  localparam int IDX_W = $clog2(TAP_N + 1);
  localparam int SEL_W = $clog2(TAP_N);
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(TAP_N);
  localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_GAIN = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_COEF = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h2C);

  logic             idle_ok, run_bit, load_bit, load_done, tbl_ok;
  logic [IDX_W-1:0] idx;
  logic [TAP_W-1:0] tbl [TAP_N];
  logic [31:0]      rd_mux;

  wire ctrl_wr = wr_en && addr == A_CTRL;
  wire coef_wr = wr_en && addr == A_COEF;
  wire load_rise = ctrl_wr && wdata[1] && !load_bit;
  wire room = idx < LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_ok <= 1'b1;
      gain_a  <= '0;
      gain_b  <= '0;
    end else if (wr_en) begin
      if (addr == A_CFG) idle_ok <= wdata[0];
      if (addr == A_GAIN) begin
        gain_a <= wdata[15:0];
        gain_b <= wdata[31:16];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_bit   <= 1'b0;
      load_bit  <= 1'b0;
      load_done <= 1'b0;
      tbl_ok    <= 1'b0;
      idx       <= '0;
    end else if (ctrl_wr) begin
      run_bit  <= wdata[0];
      load_bit <= wdata[1];
      if (!wdata[1]) load_done <= 1'b0;
      if (load_rise) begin
        idx       <= '0;
        load_done <= 1'b0;
        tbl_ok    <= 1'b0;
      end
    end else begin
      if (coef_wr && load_bit && room) idx <= idx + 1'b1;
      if (load_bit && idx == LAST) begin
        load_done <= 1'b1;
        tbl_ok    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAP_N; i++) tbl[i] <= '0;
    end else if (coef_wr && load_bit && room) begin
      tbl[idx[SEL_W-1:0]] <= wdata[TAP_W-1:0];
    end
  end

  for (genvar g = 0; g < TAP_N; g++) begin : g_out
    assign taps[g*TAP_W +: TAP_W] = tbl[g];
  end

  assign path_on  = run_bit && tbl_ok;
  assign gate_req = idle_ok;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_REV:  rd_mux = REV_VALUE;
      A_CFG:  rd_mux = {31'd0, idle_ok};
      A_GAIN: rd_mux = {gain_b, gain_a};
      A_CTRL: rd_mux = {29'd0, load_done, load_bit, run_bit};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST); // R8
  AST_DONE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> load_bit); // R9
  AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_bit) |-> (idx == '0 && !load_done && !tbl_ok)); // R9
  AST_DONE_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done) |-> $past(idx) == LAST); // R8
  AST_COEF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_wr && !load_bit) |=> $stable(idx)); // R7
  AST_REV_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_REV) |=> rdata == REV_VALUE); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R12
  AST_PATH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(path_on) |-> (run_bit && (tbl_ok || $past(idx) == LAST))); // R10

endmodule

// File: tb/stn_cfg_regs_test.sv
module stn_cfg_regs_test;
  localparam int N = 128;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [N*16-1:0] taps;
  logic [15:0] gain_a, gain_b;
  logic path_on, gate_req;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  stn_cfg_regs uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .taps(taps), .gain_a(gain_a),
    .gain_b(gain_b), .path_on(path_on), .gate_req(gate_req));

  always #10 clk = ~clk;

  function automatic logic [15:0] pat(int i, int s);
    return 16'((i * 257 + s * 4099) ^ 16'hA5C3);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  initial forever begin
    @(posedge clk);
    if (rd_en) begin
      @(negedge clk);
      check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 gain_a", {16'd0, gain_a}, 0);
    check("R1 gain_b", {16'd0, gain_b}, 0);
    check("R1 gate_req", {31'd0, gate_req}, 1);
    check("R1 path_on", {31'd0, path_on}, 0);
    check("R1 rdata", rdata, 0);
    rd(8'h2C, 0, "R1 ctrl");
    rd(8'h10, 1, "R1 cfg");

    rd(8'h00, 32'h10, "R2 rev");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h10, "R2 rev after write");

    wr(8'h10, 0);
    check("R3 gate_req low", {31'd0, gate_req}, 0);
    rd(8'h10, 0, "R3 cfg readback");
    wr(8'h10, 1);
    check("R3 gate_req high", {31'd0, gate_req}, 1);

    wr(8'h24, 32'h8001_7FFE);
    check("R4 gain_a", {16'd0, gain_a}, 32'h7FFE);
    check("R4 gain_b", {16'd0, gain_b}, 32'h8001);
    rd(8'h24, 32'h8001_7FFE, "R4 readback");

    wr(8'h18, 32'hFFFF); wr(8'h1C, 32'hFFFF); wr(8'h3C, 32'hFFFF);
    rd(8'h18, 0, "R11 0x18"); rd(8'h1C, 0, "R11 0x1C"); rd(8'h3C, 0, "R11 0x3C");
    check("R11 gains untouched", {gain_b, gain_a}, 32'h8001_7FFE);

    wr(8'h28, 32'h1234);
    check("R7 tap0 untouched", {16'd0, taps[15:0]}, 0);
    rd(8'h28, 0, "R7 coef read");

    wr(8'h2C, 32'h5);
    rd(8'h2C, 1, "R5 done bit read-only");
    check("R10 enable without table", {31'd0, path_on}, 0);

    wr(8'h2C, 32'h3);
    rd(8'h2C, 3, "R5 ctrl bits");
    for (int i = 0; i < N; i++) begin
      wr(8'h28, {16'hDEAD, pat(i, 0)});
      if (i == 63) check("R10 half table", {31'd0, path_on}, 0);
    end
    rd(8'h2C, 3, "R8 done not yet");
    rd(8'h2C, 7, "R8 done set");
    check("R10 full table", {31'd0, path_on}, 1);
    for (int i = 0; i < N; i++)
      check($sformatf("R6 tap %0d", i), {16'd0, taps[i*16 +: 16]}, {16'd0, pat(i, 0)});
    wr(8'h28, 32'h0000_7777);
    check("R8 extra write tap0", {16'd0, taps[15:0]}, {16'd0, pat(0, 0)});
    check("R8 extra write tap127", {16'd0, taps[127*16 +: 16]}, {16'd0, pat(127, 0)});

    wr(8'h2C, 32'h1);
    rd(8'h2C, 1, "R9 clear drops done");
    check("R10 stays on", {31'd0, path_on}, 1);
    repeat (3) @(negedge clk);
    check("R12 rdata holds", rdata, 1);

    wr(8'h2C, 32'h3);
    check("R9 restart drops path", {31'd0, path_on}, 0);
    for (int i = 0; i < 3; i++) wr(8'h28, {16'd0, pat(i, 1)});
    for (int i = 0; i < 3; i++)
      check($sformatf("R9 restarted tap %0d", i), {16'd0, taps[i*16 +: 16]}, {16'd0, pat(i, 1)});
    check("R9 tap3 old", {16'd0, taps[3*16 +: 16]}, {16'd0, pat(3, 0)});
    rd(8'h2C, 3, "R9 done cleared");
    check("R10 partial reload", {31'd0, path_on}, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule